// File: doc/BRIEF.md
# Prioritized Maskable Interrupt Vector Arbiter

This block sits between a set of peripheral interrupt request lines and the CPU's exception sequencer. Each request line owns a two-byte vector slot. The slots are stacked upward from a base address of 0xFFE0. The software-interrupt event occupies the topmost slot at 0xFFFC. A request is qualified when both of these hold:
- its local enable is set;
- the global interrupt mask is clear.

The software-interrupt source (index 14) is the only one that passes the global mask.

The arbiter looks at requests only when the core flags the final cycle of an instruction. At that point it picks the qualified request with the highest slot index and latches two outputs: a pending flag, and that source's vector address. A request must already have been present in the cycle before the final cycle to qualify. A late arrival therefore waits for the next instruction's final cycle.

When the sequencer reports the vector fetch, the arbiter sends a one-cycle acknowledge to the chosen source and drops the pending flag.

Top module: `irq_vector_arbiter`

## Requirements
- R1: While reset is low and in the first cycle after it, `irq_pend` is 0, `ack` is all zeros and `vec_addr` is 0xFFE0.
- R2: When `last_cycle` is high and no vector fetch takes a pending request, `irq_pend` after the clock edge is 1 exactly when at least one request is qualified. Qualified means all of the following hold in that cycle:
  - `req` is high now and was high in the previous cycle;
  - `local_en` is high;
  - `gmask` is low, or the request is the software interrupt.
- R3: Among qualified requests, the one with the highest index wins; index 14 (software interrupt) is highest and index 0 lowest.
- R4: On a sample with a winner, `vec_addr` becomes 0xFFE0 + 2 × winner index (index 9 gives 0xFFF2, index 14 gives 0xFFFC).
- R5: A request that rises in the same cycle as `last_cycle` is not taken then; if still held, it is taken at the next `last_cycle`.
- R6: With `gmask` = 1, sources 0 to 13 are ignored; source 14 is still taken.
- R7: A source whose `local_en` bit is 0 is never taken.
- R8: In cycles without `last_cycle` and without a taken fetch, `irq_pend` and `vec_addr` keep their values whatever `req`, `local_en` or `gmask` do.
- R9: `vec_fetch` while `irq_pend` is 1 makes `ack` equal to the one-hot code of the latched winner for exactly the next cycle, and clears `irq_pend`.
- R10: `vec_fetch` while `irq_pend` is 0 produces no acknowledge.
- R11: If `vec_fetch` takes a pending request in the same cycle as `last_cycle`, the sample is skipped. The acknowledge is issued and `irq_pend` is 0 afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req | input | 15 | Request lines, index = vector slot (14 = software interrupt) |
| local_en | input | 15 | Per-source enable |
| gmask | input | 1 | Global interrupt mask, 1 = masked |
| last_cycle | input | 1 | Core is in the last cycle of the current instruction |
| vec_fetch | input | 1 | Sequencer is fetching the interrupt vector |
| irq_pend | output | 1 | An interrupt has been recognized and awaits its vector fetch |
| vec_addr | output | 16 | Vector address of the recognized source |
| ack | output | 15 | One-cycle one-hot acknowledge to the taken source |

## Verification
The vector fetch that takes a pending request and the instruction-boundary sample can land in the same cycle; here the fetch must win, the acknowledge must go to the old winner, and the pending flag must end low. The bench provokes this in a directed case, holding a fresh qualified request across the coinciding cycle. It also lets random `last_cycle` and `vec_fetch` strobes overlap freely. A bench model that applies the fetch-first rule judges every cycle's pending flag, address and acknowledge.

// File: rtl/irq_vector_arbiter.sv
module irq_vector_arbiter #(
  parameter int NUM_SRC = 15,
  parameter int ADDR_W = 16,
  parameter logic [ADDR_W-1:0] VEC_BASE = 16'hFFE0
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] req,
  input  logic [NUM_SRC-1:0] local_en,
  input  logic               gmask,
  input  logic               last_cycle,
  input  logic               vec_fetch,
  output logic               irq_pend,
  output logic [ADDR_W-1:0]  vec_addr,
  output logic [NUM_SRC-1:0] ack
);
  localparam int IDX_W = $clog2(NUM_SRC);
  localparam int SWI_IDX = NUM_SRC - 1;
  localparam logic [NUM_SRC-1:0] SWI_BIT = NUM_SRC'(1) << SWI_IDX;

  logic [NUM_SRC-1:0] req_q;
  logic [NUM_SRC-1:0] unmasked;
  logic [NUM_SRC-1:0] eligible;
  logic [IDX_W-1:0]   win_idx;
  logic [IDX_W-1:0]   sel_idx;
  logic               take;

  assign unmasked = gmask ? SWI_BIT : {NUM_SRC{1'b1}};
  assign eligible = req & req_q & local_en & unmasked;
  assign take = vec_fetch & irq_pend;

  always_comb begin
    win_idx = '0;
    for (int i = 0; i < NUM_SRC; i++)
      if (eligible[i]) win_idx = IDX_W'(i);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      req_q    <= '0;
      irq_pend <= 1'b0;
      sel_idx  <= '0;
      vec_addr <= VEC_BASE;
      ack      <= '0;
    end else begin
      req_q <= req;
      if (take) begin
        ack      <= NUM_SRC'(1) << sel_idx;
        irq_pend <= 1'b0;
      end else begin
        ack <= '0;
        if (last_cycle) begin
          irq_pend <= |eligible;
          if (|eligible) begin
            sel_idx  <= win_idx;
            vec_addr <= VEC_BASE + (ADDR_W'(win_idx) << 1);
          end
        end
      end
    end
  end
endmodule

// File: rtl/irq_vector_arbiter_chk.sv
module irq_vector_arbiter_chk #(
  parameter int NUM_SRC = 15,
  parameter int ADDR_W = 16,
  parameter logic [ADDR_W-1:0] VEC_BASE = 16'hFFE0
) (
  input logic               clk,
  input logic               rst_n,
  input logic [NUM_SRC-1:0] req,
  input logic [NUM_SRC-1:0] local_en,
  input logic               gmask,
  input logic               last_cycle,
  input logic               vec_fetch,
  input logic               irq_pend,
  input logic [ADDR_W-1:0]  vec_addr,
  input logic [NUM_SRC-1:0] ack
);
  assert_ack_onehot_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(ack));

  assert_ack_after_fetch_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (vec_fetch && irq_pend) |=> ($countones(ack) == 1 && !irq_pend));

  assert_no_spurious_ack_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !(vec_fetch && irq_pend) |=> (ack == '0));

  assert_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!last_cycle && !(vec_fetch && irq_pend)) |=> ($stable(irq_pend) && $stable(vec_addr)));

  assert_vec_slot_R4: assert property (@(posedge clk) disable iff (!rst_n)
    irq_pend |-> (vec_addr[0] == 1'b0 && vec_addr >= VEC_BASE));

  assert_gmask_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (last_cycle && !(vec_fetch && irq_pend) && gmask && !req[NUM_SRC-1]) |=> !irq_pend);

  assert_local_en_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (last_cycle && !(vec_fetch && irq_pend) && ((req & local_en) == '0)) |=> !irq_pend);

  assert_coincide_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (last_cycle && vec_fetch && irq_pend) |=> !irq_pend);
endmodule

bind irq_vector_arbiter irq_vector_arbiter_chk #(
  .NUM_SRC(NUM_SRC), .ADDR_W(ADDR_W), .VEC_BASE(VEC_BASE)
) chk_i (
  .clk(clk), .rst_n(rst_n), .req(req), .local_en(local_en), .gmask(gmask),
  .last_cycle(last_cycle), .vec_fetch(vec_fetch), .irq_pend(irq_pend),
  .vec_addr(vec_addr), .ack(ack)
);

// File: tb/irq_vector_arbiter_tb_top.sv
`timescale 1ns/1ps
module irq_vector_arbiter_tb_top;
  localparam int N = 15;
  localparam logic [15:0] BASE = 16'hFFE0;
  localparam logic [N-1:0] ALL = {N{1'b1}};

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [N-1:0] req = '0, local_en = '0;
  logic gmask = 1'b0, last_cycle = 1'b0, vec_fetch = 1'b0;
  logic irq_pend;
  logic [15:0] vec_addr;
  logic [N-1:0] ack;

  int checks = 0, errors = 0;
  bit done = 0;

  logic [N-1:0] m_prev = '0;
  logic m_pend = 0;
  int m_sel = 0;
  logic [15:0] m_vec = BASE;
  logic [N-1:0] m_ack = '0;

  always #2.5 clk = ~clk;

  irq_vector_arbiter dut_i (
    .clk(clk), .rst_n(rst_n), .req(req), .local_en(local_en), .gmask(gmask),
    .last_cycle(last_cycle), .vec_fetch(vec_fetch), .irq_pend(irq_pend),
    .vec_addr(vec_addr), .ack(ack)
  );

  task automatic chk(string tag, logic [15:0] got, logic [15:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got %h expected %h", tag, got, exp);
    end
  endtask

  function automatic int top_index(logic [N-1:0] v);
    int w = -1;
    for (int i = 0; i < N; i++) if (v[i]) w = i;
    return w;
  endfunction

  function automatic logic [N-1:0] qualify(logic [N-1:0] r, logic [N-1:0] p,
                                           logic [N-1:0] e, logic gm);
    logic [N-1:0] um = gm ? (N'(1) << (N-1)) : ALL;
    return r & p & e & um;
  endfunction

  task automatic step(string tag, logic [N-1:0] r, logic [N-1:0] e,
                      logic gm, logic lc, logic vf);
    logic [N-1:0] q;
    int w;
    req = r; local_en = e; gmask = gm; last_cycle = lc; vec_fetch = vf;
    q = qualify(r, m_prev, e, gm);
    m_ack = '0;
    if (vf && m_pend) begin
      m_ack = N'(1) << m_sel;
      m_pend = 0;
    end else if (lc) begin
      w = top_index(q);
      m_pend = (w >= 0);
      if (w >= 0) begin
        m_sel = w;
        m_vec = BASE + 16'(2 * w);
      end
    end
    m_prev = r;
    @(negedge clk);
    chk({tag, " pend"}, 16'(irq_pend), 16'(m_pend));
    chk({tag, " vec"}, vec_addr, m_vec);
    chk({tag, " ack"}, 16'(ack), 16'(m_ack));
  endtask

  initial begin
    #(5.0 * 200000);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [N-1:0] rr;
    void'($urandom(32'h5eed));
    repeat (3) @(negedge clk);
    chk("R1 pend in reset", 16'(irq_pend), 16'd0);
    chk("R1 ack in reset", 16'(ack), 16'd0);
    chk("R1 vec in reset", vec_addr, BASE);
    rst_n = 1'b1;
    step("R1", '0, ALL, 0, 0, 0);

    // R3/R4: two held requests, highest index wins
    step("R3", N'(15'h0204), ALL, 0, 0, 0);
    step("R3", N'(15'h0204), ALL, 0, 1, 0);
    chk("R4 vec idx9", vec_addr, 16'hFFF2);
    // R9: acknowledge once
    step("R9", '0, ALL, 0, 0, 1);
    chk("R9 ack bit9", 16'(ack), 16'h0200);
    step("R9", '0, ALL, 0, 0, 0);
    chk("R9 single pulse", 16'(ack), 16'h0000);
    // R10: fetch with nothing pending
    step("R10", '0, ALL, 0, 0, 1);
    chk("R10 no ack", 16'(ack), 16'h0000);
    // R5: late request deferred
    step("R5", N'(15'h0020), ALL, 0, 1, 0);
    chk("R5 late not taken", 16'(irq_pend), 16'd0);
    step("R5", N'(15'h0020), ALL, 0, 0, 0);
    step("R5", N'(15'h0020), ALL, 0, 1, 0);
    chk("R5 taken next", 16'(irq_pend), 16'd1);
    chk("R5 vec idx5", vec_addr, 16'hFFEA);
    // R8: no sample, inputs wiggle
    step("R8", N'(15'h7FFF), ALL, 1, 0, 0);
    step("R8", N'(15'h4000), '0, 0, 0, 0);
    chk("R8 vec held", vec_addr, 16'hFFEA);
    step("R8", '0, ALL, 0, 0, 1);
    // R6: global mask
    step("R6", N'(15'h2000), ALL, 1, 0, 0);
    step("R6", N'(15'h2000), ALL, 1, 1, 0);
    chk("R6 masked", 16'(irq_pend), 16'd0);
    step("R6", N'(15'h6000), ALL, 1, 0, 0);
    step("R6", N'(15'h6000), ALL, 1, 1, 0);
    chk("R6 swi passes", vec_addr, 16'hFFFC);
    step("R6", '0, ALL, 0, 0, 1);
    // R7: local enable
    step("R7", N'(15'h0080), ALL & ~N'(15'h0080), 0, 0, 0);
    step("R7", N'(15'h0080), ALL & ~N'(15'h0080), 0, 1, 0);
    chk("R7 disabled", 16'(irq_pend), 16'd0);
    // R11: fetch and sample coincide
    step("R11", N'(15'h0008), ALL, 0, 0, 0);
    step("R11", N'(15'h0008), ALL, 0, 1, 0);
    step("R11", N'(15'h0408), ALL, 0, 0, 0);
    step("R11", N'(15'h0408), ALL, 0, 1, 1);
    chk("R11 ack idx3", 16'(ack), 16'h0008);
    chk("R11 pend low", 16'(irq_pend), 16'd0);

    // R2: random mix
    rr = '0;
    for (int k = 0; k < 2000; k++) begin
      rr = (rr & N'($urandom)) | (N'($urandom) & N'($urandom) & N'($urandom));
      step("R2", rr, N'($urandom) | N'($urandom), ($urandom % 4) == 0,
           ($urandom % 4) == 0, ($urandom % 3) == 0);
    end

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule